// File: doc/BRIEF.md
# Two-Tier Priority Interrupt Arbiter

This block collects interrupt requests from a set of peripheral sources and chooses one of them for the CPU each cycle. Every source carries a pending flag, an enable bit, a group bit that places it in the high or the low priority group, and a route bit that sends it to the CPU or to a data-transfer controller. A source's vector number is a fixed base plus its index, so a lower index always means a lower vector number. Within the CPU path, the high group wins first. Inside one group, the lowest vector wins.

The CPU path looks at a two-bit mask input and drops groups that the CPU does not currently accept. While the CPU acknowledges, it freezes its result. The transfer path picks its own winner among sources routed to it, using fixed vector order. It ignores the mask and the acknowledge. Both results are registered, so they appear one clock after the inputs that produce them.

Top module: `irq_arb_top`

## Requirements
- R1: A source whose enable bit is 0 is never chosen by either path, whatever its pending flag.
- R2: In the CPU path, any eligible source in the high group (levelHigh bit 1) beats every source in the low group, regardless of index; irqLevel reports 1 when the winner is in the high group.
- R3: Among eligible sources of one group, the lowest index wins; the vector presented is VEC_BASE plus that index.
- R4: cpuMask encoding: 2'b00 accepts both groups, 2'b01 accepts only the high group, 2'b10 and 2'b11 accept no group; irqReq is 1 only when an accepted eligible source exists.
- R5: A source with xferSel 1 goes only to the transfer path; xferReq and xferVec follow the lowest-index enabled pending such source, whatever cpuMask and ackIn are.
- R6: All outputs are registered: a change on the inputs reaches the outputs only at the next rising clock edge.
- R7: While ackIn is 1 at a rising edge, irqReq, irqLevel and irqVec keep their values.
- R8: When no source qualifies for a path, that path's request output is 0 and its vector output is 0.
- R9: While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqFlag | input | NUM_SRC | Pending flag of each source |
| enable | input | NUM_SRC | Enable bit of each source |
| levelHigh | input | NUM_SRC | 1 places the source in the high group |
| xferSel | input | NUM_SRC | 1 routes the source to the transfer path |
| cpuMask | input | 2 | CPU group mask, encoded as in R4 |
| ackIn | input | 1 | CPU acknowledge; freezes the CPU result |
| irqReq | output | 1 | CPU interrupt request |
| irqLevel | output | 1 | Group of the presented CPU winner |
| irqVec | output | VEC_W | Vector of the presented CPU winner |
| xferReq | output | 1 | Transfer-controller start request |
| xferVec | output | VEC_W | Vector of the transfer winner |

## Verification
The CPU path and the transfer path can both act in the same cycle. The interesting case is a cycle where the CPU side is blocked by a mask or frozen by an acknowledge while the transfer side must still move. The bench provokes this in two ways. One directed case sets a full mask while a transfer-routed and a CPU-routed source are both pending. The random phase drives mixed route bits, random masks and random acknowledge pulses together. In both, the bench models each path separately and compares each path's outputs with its own model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdCpu;    // freeze CPU result this edge
    logic allowHigh;  // high group accepted by CPU
    logic allowLow;   // low group accepted by CPU
  } arbStrobe_t;

endpackage

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  // Lowest set index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic [1:0]  cpuMask,
  input  logic        ackIn,
  output arbStrobe_t  strobe
);

  always_comb begin
    strobe.holdCpu   = ackIn;
    strobe.allowHigh = ~cpuMask[1];
    strobe.allowLow  = (cpuMask == 2'b00);
  end

endmodule

// File: rtl/irq_arb_dpath.sv
module irq_arb_dpath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] reqFlag,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] levelHigh,
  input  logic [NUM_SRC-1:0] xferSel,
  output logic               irqReq,
  output logic               irqLevel,
  output logic [VEC_W-1:0]   irqVec,
  output logic               xferReq,
  output logic [VEC_W-1:0]   xferVec
);

  logic [NUM_SRC-1:0] live, hiSet, loSet, xSet;
  logic hiFound, loFound, xFound;
  logic [IDX_W-1:0] hiIdx, loIdx, xIdx;

  always_comb begin
    live  = reqFlag & enable;
    hiSet = live & ~xferSel & levelHigh  & {NUM_SRC{strobe.allowHigh}};
    loSet = live & ~xferSel & ~levelHigh & {NUM_SRC{strobe.allowLow}};
    xSet  = live & xferSel;
  end

  irq_arb_pick #(.NUM_SRC(NUM_SRC)) uPickHi (.cand(hiSet), .found(hiFound), .idx(hiIdx));
  irq_arb_pick #(.NUM_SRC(NUM_SRC)) uPickLo (.cand(loSet), .found(loFound), .idx(loIdx));
  irq_arb_pick #(.NUM_SRC(NUM_SRC)) uPickX  (.cand(xSet),  .found(xFound),  .idx(xIdx));

  function automatic logic [VEC_W-1:0] toVec(input logic [IDX_W-1:0] k);
    return VEC_W'(VEC_BASE) + VEC_W'(k);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      irqLevel <= 1'b0;
      irqVec   <= '0;
      xferReq  <= 1'b0;
      xferVec  <= '0;
    end else begin
      if (!strobe.holdCpu) begin
        irqReq   <= hiFound | loFound;
        irqLevel <= hiFound;
        irqVec   <= hiFound ? toVec(hiIdx) : (loFound ? toVec(loIdx) : '0);
      end
      xferReq <= xFound;
      xferVec <= xFound ? toVec(xIdx) : '0;
    end
  end

  // R8
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVec == '0 && !irqLevel));

  // R8
  idle_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferReq |-> (xferVec == '0));

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqFlag,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] levelHigh,
  input  logic [NUM_SRC-1:0] xferSel,
  input  logic [1:0]         cpuMask,
  input  logic               ackIn,
  output logic               irqReq,
  output logic               irqLevel,
  output logic [VEC_W-1:0]   irqVec,
  output logic               xferReq,
  output logic [VEC_W-1:0]   xferVec
);

  arbStrobe_t strobe;

  irq_arb_ctrl uCtrl (
    .cpuMask (cpuMask),
    .ackIn   (ackIn),
    .strobe  (strobe)
  );

  irq_arb_dpath #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqFlag   (reqFlag),
    .enable    (enable),
    .levelHigh (levelHigh),
    .xferSel   (xferSel),
    .irqReq    (irqReq),
    .irqLevel  (irqLevel),
    .irqVec    (irqVec),
    .xferReq   (xferReq),
    .xferVec   (xferVec)
  );

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> ($stable(irqReq) && $stable(irqVec) && $stable(irqLevel)));

  // R4
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMask[1] && !ackIn) |=> !irqReq);

  // R4
  mask_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMask == 2'b01 && !ackIn) |=> (!irqReq || irqLevel));

  // R1
  none_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqFlag & enable) == '0 && !ackIn) |=> (!irqReq && !xferReq));

endmodule

// File: tb/tb_irq_arb_top.sv
module tb_irq_arb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int VB = 16;

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0] reqFlag, enable, levelHigh, xferSel;
  logic [1:0] cpuMask;
  logic ackIn;
  logic irqReq, irqLevel, xferReq;
  logic [7:0] irqVec, xferVec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic eReq, eLvl, eXReq;
  logic [7:0] eVec, eXVec;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arb_top dut (
    .clk(clk), .rstN(rstN), .reqFlag(reqFlag), .enable(enable),
    .levelHigh(levelHigh), .xferSel(xferSel), .cpuMask(cpuMask), .ackIn(ackIn),
    .irqReq(irqReq), .irqLevel(irqLevel), .irqVec(irqVec),
    .xferReq(xferReq), .xferVec(xferVec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of next register values from current inputs
  task automatic model();
    logic aHi, aLo, hit;
    aHi = !cpuMask[1];
    aLo = (cpuMask == 2'b00);
    if (!ackIn) begin
      eReq = 0; eLvl = 0; eVec = 0; hit = 0;
      for (int i = 0; i < N; i++)
        if (!hit && aHi && reqFlag[i] && enable[i] && !xferSel[i] && levelHigh[i]) begin
          hit = 1; eReq = 1; eLvl = 1; eVec = 8'(VB + i);
        end
      for (int i = 0; i < N; i++)
        if (!hit && aLo && reqFlag[i] && enable[i] && !xferSel[i] && !levelHigh[i]) begin
          hit = 1; eReq = 1; eVec = 8'(VB + i);
        end
    end
    eXReq = 0; eXVec = 0; hit = 0;
    for (int i = 0; i < N; i++)
      if (!hit && reqFlag[i] && enable[i] && xferSel[i]) begin
        hit = 1; eXReq = 1; eXVec = 8'(VB + i);
      end
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk); #2;
    chk({tag, " irqReq"}, int'(irqReq), int'(eReq));
    chk({tag, " irqLevel"}, int'(irqLevel), int'(eLvl));
    chk({tag, " irqVec"}, int'(irqVec), int'(eVec));
    chk({tag, " xferReq"}, int'(xferReq), int'(eXReq));
    chk({tag, " xferVec"}, int'(xferVec), int'(eXVec));
    @(negedge clk);
  endtask

  task automatic clearIn();
    reqFlag = '0; enable = '0; levelHigh = '0; xferSel = '0;
    cpuMask = 2'b00; ackIn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    clearIn();
    rstN = 1'b0;
    eReq = 0; eLvl = 0; eVec = 0; eXReq = 0; eXVec = 0;
    // R9: reset drives outputs to zero even with requests pending
    reqFlag = 8'hFF; enable = 8'hFF;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 irqReq", int'(irqReq), 0);
    chk("R9 irqVec", int'(irqVec), 0);
    chk("R9 xferReq", int'(xferReq), 0);
    @(negedge clk);
    clearIn();
    rstN = 1'b1;
    step("R8");

    // R1: disabled source 2 ignored, enabled low source 5 wins
    reqFlag = 8'b0010_0100; enable = 8'b0010_0000;
    step("R1");
    // R2: high source 6 beats low source 1
    clearIn(); reqFlag = 8'b0100_0010; enable = 8'hFF; levelHigh = 8'b0100_0000;
    step("R2");
    // R6: new input not visible before the edge
    clearIn(); reqFlag = 8'b0001_1000; enable = 8'hFF;
    #1;
    chk("R6 vec before edge", int'(irqVec), VB + 6);
    // R3: sources 3 and 4 both low, 3 wins
    step("R3");
    // R4: mask low group
    cpuMask = 2'b01;
    step("R4 mask01 low");
    levelHigh = 8'b0001_0000;
    step("R4 mask01 high");
    cpuMask = 2'b10;
    step("R4 mask10");
    cpuMask = 2'b11;
    // R5: transfer source 0 fires despite full mask
    xferSel = 8'b0000_0001; reqFlag = 8'b0001_1001;
    step("R5");
    // R7: ack freezes CPU result
    clearIn(); reqFlag = 8'b0001_0000; enable = 8'hFF;
    step("R7 setup");
    ackIn = 1'b1; reqFlag = 8'b0001_0010; levelHigh = 8'b0000_0010;
    step("R7 hold");
    chk("R7 held vec", int'(irqVec), VB + 4);
    ackIn = 1'b0;
    step("R7 release");
    // R8: nothing pending
    clearIn();
    step("R8 idle");

    // Random phase
    for (int k = 0; k < 400; k++) begin
      reqFlag   = N'($urandom);
      enable    = N'($urandom);
      levelHigh = N'($urandom);
      xferSel   = N'($urandom) & N'($urandom);
      cpuMask   = 2'($urandom);
      ackIn     = ($urandom % 4) == 0;
      step("R3 R4 R5 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule